// File: doc/BRIEF.md
# PCIe Root Port Bring-Up Sequencer

This block walks a PCIe controller wrapper out of power-on reset and into root-complex operation without any processor help. A single start pulse launches a fixed sequence. The sequence first pulls every link and PHY reset low and hands the internal reset sources over to hardware control. It then parks link training, writes the root-complex device type, and waits a timed interval for the reference clock to settle. After that it releases the endpoint reset pair, flags auxiliary power, and ungates the three AXI clock domains one request/ungate pair at a time. Finally it releases the power-up reset and then the button reset, and enables link training.

When the last step is taken, a done flag rises and stays high. From then on the block reports link-up by mirroring a synchronised copy of the controller's raw link-up signal. A start pulse after done runs the whole sequence again from the reset step. Start pulses that arrive while the sequence is running are ignored. The settle interval is `WAIT_US * CYC_PER_US` clock cycles. Below, W stands for that count, and edge E0 is the rising clock edge that samples an accepted start.

Top module: `pcie_rp_bringup`

## Requirements
- R1: While rst_n is low, and after it: ep_rst_in_n, ep_rst_out_n, pwup_rst_n and btn_rst_n are 0; rst_src_sel is 0; dev_type is 0; aux_pwr_det, axi_clk_req, ltssm_en, done and link_up are 0; axi_clk_stop is all ones.
- R2: At E1, all four reset outputs go low. rst_src_sel bits [2:0] (endpoint reset, power-up reset, button reset) become 0, meaning register control. Bits [11:3] (power, AXI master, AXI slave, DBI, core, sticky, non-sticky, squelch, PHY) become 1, meaning hardware control.
- R3: ltssm_en is 0 after E2, and dev_type becomes 4 (root complex) at E3, before any endpoint reset release.
- R4: ep_rst_in_n and ep_rst_out_n both rise together at E(4+W) and at no earlier edge.
- R5: aux_pwr_det rises at E(5+W), after the endpoint reset release and before any AXI clock request.
- R6: For AXI port p (0 = master, 1 = slave, 2 = DBI), axi_clk_req[p] rises at E(6+W+2p) and axi_clk_stop[p] clears at E(7+W+2p). A clock request always comes before its matching ungate.
- R7: pwup_rst_n rises at E(12+W), btn_rst_n rises at E(13+W), and ltssm_en rises at E(14+W).
- R8: done falls at E0 and rises at E(15+W), then holds until the next accepted start.
- R9: link_up equals done AND the value of link_up_raw sampled two clock edges earlier.
- R10: A start pulse while the sequence is running has no effect on any output or on the timing of later steps.
- R11: A start after done reasserts the four reset outputs at E1 and then repeats the full timeline. The AXI clocks stay ungated during the rerun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts the bring-up sequence when idle or done |
| link_up_raw | input | 1 | Asynchronous link-up indication from the controller |
| ep_rst_in_n | output | 1 | Endpoint reset, input side, active low |
| ep_rst_out_n | output | 1 | Endpoint reset, output side, active low |
| pwup_rst_n | output | 1 | Power-up reset, active low |
| btn_rst_n | output | 1 | Button reset, active low |
| rst_src_sel | output | 12 | Per-source reset select (0 = register, 1 = hardware) |
| dev_type | output | 4 | Controller device type field |
| aux_pwr_det | output | 1 | Auxiliary power detect |
| axi_clk_req | output | 3 | AXI clock request per port (master, slave, DBI) |
| axi_clk_stop | output | 3 | AXI clock stop per port, 1 = gated |
| ltssm_en | output | 1 | Link training enable |
| done | output | 1 | Sequence complete |
| link_up | output | 1 | Synchronised link-up, qualified by done |

## Verification
The bench runs the sequence from a cold reset, then runs it again after done. This separates a rerun that truly restarts at the reset step from one that skips ahead or re-gates clocks. Stray start pulses are placed during the settle wait and again inside the clock-ungating phase. Any restart or shift in the timeline shows up as a moved done edge. link_up_raw is raised before done and lowered after done, which tells the done qualification apart from the two-edge synchroniser latency. A reset in the middle of a run confirms that every output returns to its idle value.

// File: rtl/pcie_rp_bringup_pkg.sv
package pcie_rp_bringup_pkg;
   localparam int NUM_REG_SRC = 3;
   localparam int NUM_HW_SRC  = 9;
   localparam int NUM_RST_SRC = NUM_REG_SRC + NUM_HW_SRC;
   localparam int NUM_AXI     = 3;
   localparam int CLK_STEPS   = 2 * NUM_AXI;
   localparam int CLK_IDX_W   = $clog2(CLK_STEPS);

   localparam logic [3:0] RC_DEVTYPE = 4'd4;
   localparam logic [NUM_RST_SRC-1:0] HW_SEL_MASK =
      {{NUM_HW_SRC{1'b1}}, {NUM_REG_SRC{1'b0}}};

   typedef enum logic [3:0] {
      ST_IDLE, ST_ASSERT, ST_LTSSM_OFF, ST_DEVTYPE, ST_WAIT,
      ST_PERST_REL, ST_AUX, ST_CLK, ST_PWUP_REL, ST_BTN_REL,
      ST_LTSSM_ON, ST_FINISH
   } bu_state_e;
endpackage

// File: rtl/bu_sync.sv
module bu_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial assert (STAGES >= 1) else $error("bu_sync: STAGES must be >= 1");

   generate
      if (STAGES == 1) begin : g_single
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], d};
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/bu_wait_timer.sv
module bu_wait_timer #(
   parameter int COUNT = 1250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int CW = $clog2(COUNT + 1);
   localparam logic [CW-1:0] LOAD_V = CW'(COUNT - 1);

   initial assert (COUNT >= 1) else $error("bu_wait_timer: COUNT must be >= 1");

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= LOAD_V;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !load) |=> expired); // R4
endmodule

// File: rtl/bu_axi_ungate.sv
module bu_axi_ungate #(
   parameter int PORTS = 3,
   parameter int IW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [IW-1:0]    idx,
   output logic [PORTS-1:0] req,
   output logic [PORTS-1:0] stop
);
   initial assert ((1 << IW) >= 2 * PORTS) else $error("bu_axi_ungate: IW too small");

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req[p]  <= 1'b0;
            stop[p] <= 1'b1;
         end else if (step) begin
            if (idx == IW'(2 * p))     req[p]  <= 1'b1;
            if (idx == IW'(2 * p + 1)) stop[p] <= 1'b0;
         end
      end

      AST_REQ_BEFORE_UNGATE: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(stop[p]) |-> req[p]); // R6
   end
endmodule

// File: rtl/pcie_rp_bringup.sv
module pcie_rp_bringup
   import pcie_rp_bringup_pkg::*;
#(
   parameter int CYC_PER_US  = 125,
   parameter int WAIT_US     = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   link_up_raw,
   output logic                   ep_rst_in_n,
   output logic                   ep_rst_out_n,
   output logic                   pwup_rst_n,
   output logic                   btn_rst_n,
   output logic [NUM_RST_SRC-1:0] rst_src_sel,
   output logic [3:0]             dev_type,
   output logic                   aux_pwr_det,
   output logic [NUM_AXI-1:0]     axi_clk_req,
   output logic [NUM_AXI-1:0]     axi_clk_stop,
   output logic                   ltssm_en,
   output logic                   done,
   output logic                   link_up
);
   localparam int WAIT_CYC = CYC_PER_US * WAIT_US;
   localparam logic [CLK_IDX_W-1:0] CLK_LAST = CLK_IDX_W'(CLK_STEPS - 1);

   initial assert (CYC_PER_US >= 1 && WAIT_US >= 1)
      else $error("pcie_rp_bringup: delay parameters must be positive");

   bu_state_e            state;
   logic [CLK_IDX_W-1:0] clk_idx;
   logic                 tmr_expired;
   logic                 link_s;

   bu_wait_timer #(.COUNT(WAIT_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (state == ST_DEVTYPE),
      .expired (tmr_expired)
   );

   bu_axi_ungate #(.PORTS(NUM_AXI), .IW(CLK_IDX_W)) u_ungate (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (state == ST_CLK),
      .idx   (clk_idx),
      .req   (axi_clk_req),
      .stop  (axi_clk_stop)
   );

   bu_sync #(.STAGES(SYNC_STAGES)) u_link_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (link_up_raw),
      .q     (link_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         ep_rst_in_n  <= 1'b0;
         ep_rst_out_n <= 1'b0;
         pwup_rst_n   <= 1'b0;
         btn_rst_n    <= 1'b0;
         rst_src_sel  <= '0;
         dev_type     <= '0;
         aux_pwr_det  <= 1'b0;
         ltssm_en     <= 1'b0;
         done         <= 1'b0;
         clk_idx      <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  done  <= 1'b0;
                  state <= ST_ASSERT;
               end
            end
            ST_ASSERT: begin
               ep_rst_in_n  <= 1'b0;
               ep_rst_out_n <= 1'b0;
               pwup_rst_n   <= 1'b0;
               btn_rst_n    <= 1'b0;
               rst_src_sel  <= HW_SEL_MASK;
               state        <= ST_LTSSM_OFF;
            end
            ST_LTSSM_OFF: begin
               ltssm_en <= 1'b0;
               state    <= ST_DEVTYPE;
            end
            ST_DEVTYPE: begin
               dev_type <= RC_DEVTYPE;
               state    <= ST_WAIT;
            end
            ST_WAIT: begin
               if (tmr_expired) state <= ST_PERST_REL;
            end
            ST_PERST_REL: begin
               ep_rst_in_n  <= 1'b1;
               ep_rst_out_n <= 1'b1;
               state        <= ST_AUX;
            end
            ST_AUX: begin
               aux_pwr_det <= 1'b1;
               clk_idx     <= '0;
               state       <= ST_CLK;
            end
            ST_CLK: begin
               if (clk_idx == CLK_LAST) begin
                  clk_idx <= '0;
                  state   <= ST_PWUP_REL;
               end else begin
                  clk_idx <= clk_idx + 1'b1;
               end
            end
            ST_PWUP_REL: begin
               pwup_rst_n <= 1'b1;
               state      <= ST_BTN_REL;
            end
            ST_BTN_REL: begin
               btn_rst_n <= 1'b1;
               state     <= ST_LTSSM_ON;
            end
            ST_LTSSM_ON: begin
               if (!ltssm_en) ltssm_en <= 1'b1;
               state <= ST_FINISH;
            end
            ST_FINISH: begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign link_up = done & link_s;

   AST_DEVTYPE_BEFORE_PERST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ep_rst_out_n) |-> (dev_type == RC_DEVTYPE && !ltssm_en)); // R3
   AST_PERST_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ep_rst_in_n) |-> tmr_expired); // R4
   AST_AUX_BEFORE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (axi_clk_req != $past(axi_clk_req)) |-> aux_pwr_det); // R5
   AST_PWUP_AFTER_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwup_rst_n) |-> (axi_clk_stop == '0)); // R7
   AST_BTN_AFTER_PWUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(btn_rst_n) |-> pwup_rst_n); // R7
   AST_DONE_WITH_LTSSM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (ltssm_en && btn_rst_n)); // R8
endmodule

// File: tb/pcie_rp_bringup_tb.sv
module pcie_rp_bringup_tb;
   localparam int W = 10 * 125;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic link_up_raw = 1'b0;
   logic ep_rst_in_n, ep_rst_out_n, pwup_rst_n, btn_rst_n;
   logic [11:0] rst_src_sel;
   logic [3:0]  dev_type;
   logic        aux_pwr_det, ltssm_en, done, link_up;
   logic [2:0]  axi_clk_req, axi_clk_stop;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   pcie_rp_bringup u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .link_up_raw(link_up_raw),
      .ep_rst_in_n(ep_rst_in_n), .ep_rst_out_n(ep_rst_out_n),
      .pwup_rst_n(pwup_rst_n), .btn_rst_n(btn_rst_n),
      .rst_src_sel(rst_src_sel), .dev_type(dev_type),
      .aux_pwr_det(aux_pwr_det), .axi_clk_req(axi_clk_req),
      .axi_clk_stop(axi_clk_stop), .ltssm_en(ltssm_en),
      .done(done), .link_up(link_up)
   );

   // behavioural timeline model
   bit        run = 0;
   int        t = 0;
   bit        m_ein, m_eout, m_pw, m_bt, m_aux, m_ltssm, m_done, lk1, lk2;
   bit [11:0] m_sel;
   bit [3:0]  m_dev;
   bit [2:0]  m_req, m_stop;

   task automatic model_reset();
      m_ein = 0; m_eout = 0; m_pw = 0; m_bt = 0; m_aux = 0; m_ltssm = 0;
      m_done = 0; lk1 = 0; lk2 = 0; m_sel = '0; m_dev = '0;
      m_req = '0; m_stop = 3'b111; run = 0; t = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         lk2 = lk1;
         lk1 = link_up_raw;
         if (!run) begin
            if (start) begin run = 1; t = 0; m_done = 0; end
         end else begin
            t = t + 1;
            if (t == 1) begin
               m_ein = 0; m_eout = 0; m_pw = 0; m_bt = 0; m_sel = 12'hFF8;
            end
            if (t == 2) m_ltssm = 0;
            if (t == 3) m_dev = 4'd4;
            if (t == 4 + W) begin m_ein = 1; m_eout = 1; end
            if (t == 5 + W) m_aux = 1;
            for (int p = 0; p < 3; p++) begin
               if (t == 6 + W + 2 * p) m_req[p] = 1;
               if (t == 7 + W + 2 * p) m_stop[p] = 0;
            end
            if (t == 12 + W) m_pw = 1;
            if (t == 13 + W) m_bt = 1;
            if (t == 14 + W) m_ltssm = 1;
            if (t == 15 + W) begin m_done = 1; run = 0; end
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check("R4 ep_rst pair", {ep_rst_in_n, ep_rst_out_n}, {m_ein, m_eout});
         check("R7 pwup/btn",    {pwup_rst_n, btn_rst_n},     {m_pw, m_bt});
         check("R2 rst_src_sel", rst_src_sel,                  m_sel);
         check("R3 dev_type",    dev_type,                     m_dev);
         check("R7 ltssm_en",    ltssm_en,                     m_ltssm);
         check("R5 aux_pwr_det", aux_pwr_det,                  m_aux);
         check("R6 axi clocks",  {axi_clk_req, axi_clk_stop},  {m_req, m_stop});
         check("R8 done",        done,                         m_done);
         check("R9 link_up",     link_up,                      m_done & lk2);
      end
   end

   task automatic check_reset_state(input string tag);
      check({tag, " resets"}, {ep_rst_in_n, ep_rst_out_n, pwup_rst_n, btn_rst_n}, 4'b0000);
      check({tag, " sel"},    rst_src_sel, 12'h000);
      check({tag, " dev"},    dev_type, 4'd0);
      check({tag, " misc"},   {aux_pwr_det, ltssm_en, done, link_up}, 4'b0000);
      check({tag, " clocks"}, {axi_clk_req, axi_clk_stop}, 6'b000111);
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_reset_state("R1");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // first run, stray starts during the wait and the clock phase (R10)
      pulse_start();
      repeat (1) @(negedge clk);
      check("R2 resets low", {ep_rst_in_n, ep_rst_out_n, pwup_rst_n, btn_rst_n}, 4'b0000);
      check("R2 select map", rst_src_sel, 12'hFF8);
      repeat (50) @(negedge clk);
      pulse_start();
      repeat (20) @(negedge clk);
      link_up_raw = 1'b1;
      repeat (W + 6 - 72) @(negedge clk);
      pulse_start();
      repeat (7) @(negedge clk);
      check("R10 done not early", done, 1'b0);
      check("R9 link held by done", link_up, 1'b0);
      repeat (1) @(negedge clk);
      check("R10 done on time", done, 1'b1);
      check("R9 link after done", link_up, 1'b1);

      // link drop latency (R9)
      link_up_raw = 1'b0;
      @(negedge clk);
      check("R9 link one edge", link_up, 1'b1);
      @(negedge clk);
      check("R9 link two edges", link_up, 1'b0);
      repeat (5) @(negedge clk);

      // rerun after done (R11)
      pulse_start();
      check("R8 done falls", done, 1'b0);
      repeat (1) @(negedge clk);
      check("R11 resets reasserted", {ep_rst_in_n, ep_rst_out_n, pwup_rst_n, btn_rst_n}, 4'b0000);
      check("R11 clocks stay on", {axi_clk_req, axi_clk_stop}, 6'b111000);
      repeat (13 + W) @(negedge clk);
      check("R11 done not early", done, 1'b0);
      @(negedge clk);
      check("R11 done again", done, 1'b1);
      check("R7 final state", {pwup_rst_n, btn_rst_n, ltssm_en}, 3'b111);

      // reset in the middle of a run (R1)
      repeat (4) @(negedge clk);
      pulse_start();
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_reset_state("R1 mid-run");
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check("R1 stays idle", {done, ep_rst_in_n}, 2'b00);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule